// File: doc/BRIEF.md
# Transaction-Granular Priority Crossbar Node

This block is a full crossbar that links six initiator-side flit channels to four target-side flit channels. An initiator opens a transaction with a header flit that names the destination target. Payload flits follow, and the transaction closes on the flit marked last. Each target port runs its own arbiter, so transactions bound for different targets move through the node at the same time.

When several initiators contend for one target, the arbiter picks a winner from per-initiator priority levels that software writes through a small write port. The winner keeps the target until the last flit of its transaction has been taken, so flits from different sources never interleave on a target. A single register stage sits on each target's forward path. Back-pressure from a target reaches only the initiator that currently holds it.

A header whose target field does not name an existing target is accepted and then discarded together with the rest of its transaction, and an error pulse is raised for that initiator.

Top module: `prio_xbar_node`

## Requirements
- R1: The target index is read from bits [58:56] of a header flit. A flit accepted from initiator i for target t is presented on target t's outputs in the cycle after acceptance, with the source field equal to i.
- R2: When a header is presented to an idle target and no other initiator contends, the grant is registered at the next clock edge. The initiator sees ready in the following cycle, so its header is accepted on the second edge.
- R3: Among contending initiators, the one with the numerically highest 3-bit priority wins. Equal priorities resolve to the lowest initiator index.
- R4: A granted initiator keeps its target until its last-marked flit is accepted, and no other source's flits appear on that target in between. Each initiator holds at most one target.
- R5: Transactions to different targets proceed in the same cycles without waiting on each other.
- R6: While a target holds ready low and its output register is full, the target's outputs stay stable and only the owning initiator is stalled. Other targets keep flowing.
- R7: The cycle after the granted transaction's last flit is accepted, the target is idle and arbitrates again. The next owner sees ready one cycle after that.
- R8: A header with target index 4 to 7 is accepted at once and raises a one-cycle error pulse for that initiator in the following cycle. The rest of that transaction is accepted and discarded. Nothing reaches any target.
- R9: Priority levels reset to 0 and can be written at any time, including while a transaction is in flight. A write is used by every arbitration decided after it.
- R10: After reset, no target output is valid, no error is raised and no initiator sees ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Priority write strobe |
| cfg_idx_i | input | 3 | Initiator whose priority is written |
| cfg_prio_i | input | 3 | Priority value to write |
| ini_valid_i | input | 6 | Flit valid per initiator |
| ini_flit_i | input | 6x72 | Flit per initiator |
| ini_last_i | input | 6 | Last flit of transaction per initiator |
| ini_ready_o | output | 6 | Flit accepted per initiator |
| ini_err_o | output | 6 | Bad target index pulse per initiator |
| tgt_valid_o | output | 4 | Flit valid per target |
| tgt_flit_o | output | 4x72 | Flit per target |
| tgt_last_o | output | 4 | Last flit marker per target |
| tgt_src_o | output | 4x3 | Source initiator of the presented flit |
| tgt_ready_i | input | 4 | Target accepts the presented flit |

## Verification
A target whose owner register is wrong shows up within one flit, because the source field no longer matches the initiator whose flit was accepted. A grant that is released too early shows up as interleaved sources within a single transaction. A discard state that never clears leaves the offending initiator ready forever with nothing on the outputs, and its next good transaction never arrives. Timing faults in arbitration move the first ready of a waiting initiator by a cycle, which the directed checks count at the ports.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic {TS_IDLE, TS_OWNED} tgt_state_e;
endpackage

// File: rtl/xbar_prio_arb.sv
module xbar_prio_arb #(
  parameter int N      = 6,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]             req_i,
  input  logic [N-1:0][PRIO_W-1:0] prio_i,
  output logic                     any_o,
  output logic [IDX_W-1:0]         win_o
);
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lowest index on ties
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!any_o || prio_i[i] > best)) begin
        any_o = 1'b1;
        win_o = IDX_W'(i);
        best  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/xbar_tgt_port.sv
module xbar_tgt_port
  import xbar_pkg::*;
#(
  parameter int N_INI  = 6,
  parameter int FLIT_W = 72,
  parameter int PRIO_W = 3,
  parameter int SRC_W  = $clog2(N_INI)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_INI-1:0]             req_i,
  input  logic [N_INI-1:0][PRIO_W-1:0] prio_i,
  input  logic [N_INI-1:0]             in_valid_i,
  input  logic [N_INI-1:0][FLIT_W-1:0] in_flit_i,
  input  logic [N_INI-1:0]             in_last_i,
  input  logic                         ready_i,
  output logic [N_INI-1:0]             gnt_o,
  output logic                         load_o,
  output logic                         out_valid_o,
  output logic [FLIT_W-1:0]            out_flit_o,
  output logic                         out_last_o,
  output logic [SRC_W-1:0]             out_src_o
);
  tgt_state_e        state_q;
  logic [SRC_W-1:0]  owner_q;
  logic              arb_any;
  logic [SRC_W-1:0]  arb_win;
  logic              fire, fire_last;

  xbar_prio_arb #(.N(N_INI), .PRIO_W(PRIO_W), .IDX_W(SRC_W)) u_arb (
    .req_i (req_i),
    .prio_i(prio_i),
    .any_o (arb_any),
    .win_o (arb_win)
  );

  assign load_o    = !out_valid_o || ready_i;
  assign fire      = (state_q == TS_OWNED) && in_valid_i[owner_q] && load_o;
  assign fire_last = fire && in_last_i[owner_q];

  always_comb begin
    for (int i = 0; i < N_INI; i++)
      gnt_o[i] = (state_q == TS_OWNED) && (owner_q == SRC_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= TS_IDLE;
      owner_q     <= '0;
      out_valid_o <= 1'b0;
      out_flit_o  <= '0;
      out_last_o  <= 1'b0;
      out_src_o   <= '0;
    end else begin
      if (load_o) begin
        out_valid_o <= fire;
        if (fire) begin
          out_flit_o <= in_flit_i[owner_q];
          out_last_o <= in_last_i[owner_q];
          out_src_o  <= owner_q;
        end
      end
      case (state_q)
        TS_IDLE:  if (arb_any) begin
                    state_q <= TS_OWNED;
                    owner_q <= arb_win;
                  end
        TS_OWNED: if (fire_last) state_q <= TS_IDLE;
        default:  state_q <= TS_IDLE;
      endcase
    end
  end

  p_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> out_valid_o && out_src_o == $past(owner_q));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && !fire_last) |=> $stable(gnt_o));
  p_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !ready_i) |=> out_valid_o && $stable(out_flit_o) && $stable(out_src_o));
  p_rearb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_last |=> gnt_o == '0);
endmodule

// File: rtl/prio_xbar_node.sv
module prio_xbar_node #(
  parameter int N_INI    = 6,
  parameter int N_TGT    = 4,
  parameter int FLIT_W   = 72,
  parameter int PRIO_W   = 3,
  parameter int TIDX_LSB = 56,
  parameter int TIDX_W   = 3,
  parameter int SRC_W    = $clog2(N_INI)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [SRC_W-1:0]             cfg_idx_i,
  input  logic [PRIO_W-1:0]            cfg_prio_i,
  input  logic [N_INI-1:0]             ini_valid_i,
  input  logic [N_INI-1:0][FLIT_W-1:0] ini_flit_i,
  input  logic [N_INI-1:0]             ini_last_i,
  output logic [N_INI-1:0]             ini_ready_o,
  output logic [N_INI-1:0]             ini_err_o,
  output logic [N_TGT-1:0]             tgt_valid_o,
  output logic [N_TGT-1:0][FLIT_W-1:0] tgt_flit_o,
  output logic [N_TGT-1:0]             tgt_last_o,
  output logic [N_TGT-1:0][SRC_W-1:0]  tgt_src_o,
  input  logic [N_TGT-1:0]             tgt_ready_i
);
  logic [N_INI-1:0][PRIO_W-1:0] prio_q;
  logic [N_TGT-1:0][N_INI-1:0]  req_t, gnt_t;
  logic [N_INI-1:0][N_TGT-1:0]  gnt_by_ini;
  logic [N_TGT-1:0]             load_t;
  logic [N_INI-1:0]             owns, bad_hdr, drop_q;
  logic [N_INI-1:0][TIDX_W-1:0] hdr_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prio_q <= '0;
    else if (cfg_we_i && cfg_idx_i <= SRC_W'(N_INI-1)) prio_q[cfg_idx_i] <= cfg_prio_i;
  end

  for (genvar i = 0; i < N_INI; i++) begin : g_ini
    assign hdr_idx[i] = ini_flit_i[i][TIDX_LSB +: TIDX_W];
    assign owns[i]    = |gnt_by_ini[i];
    assign bad_hdr[i] = ini_valid_i[i] && !owns[i] && !drop_q[i]
                        && hdr_idx[i] > TIDX_W'(N_TGT-1);
    assign ini_ready_o[i] = drop_q[i] || bad_hdr[i] || |(gnt_by_ini[i] & load_t);

    for (genvar t = 0; t < N_TGT; t++) begin : g_map
      assign gnt_by_ini[i][t] = gnt_t[t][i];
      assign req_t[t][i] = ini_valid_i[i] && !owns[i] && !drop_q[i]
                           && hdr_idx[i] == TIDX_W'(t);
    end

    // bad-target transaction is swallowed up to its last flit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        drop_q[i]    <= 1'b0;
        ini_err_o[i] <= 1'b0;
      end else begin
        ini_err_o[i] <= bad_hdr[i];
        if (bad_hdr[i] && !ini_last_i[i])                     drop_q[i] <= 1'b1;
        else if (drop_q[i] && ini_valid_i[i] && ini_last_i[i]) drop_q[i] <= 1'b0;
      end
    end

    p_one_owner_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_by_ini[i]));
    p_drop_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop_q[i] |-> gnt_by_ini[i] == '0);
  end

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    xbar_tgt_port #(.N_INI(N_INI), .FLIT_W(FLIT_W), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req_t[t]),
      .prio_i     (prio_q),
      .in_valid_i (ini_valid_i),
      .in_flit_i  (ini_flit_i),
      .in_last_i  (ini_last_i),
      .ready_i    (tgt_ready_i[t]),
      .gnt_o      (gnt_t[t]),
      .load_o     (load_t[t]),
      .out_valid_o(tgt_valid_o[t]),
      .out_flit_o (tgt_flit_o[t]),
      .out_last_o (tgt_last_o[t]),
      .out_src_o  (tgt_src_o[t])
    );
  end
endmodule

// File: tb/sim_prio_xbar_node.sv
module sim_prio_xbar_node;
  localparam int CLK_P = 10;
  localparam int NI = 6, NT = 4, FW = 72;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_idx = '0, cfg_prio = '0;
  logic [NI-1:0] iv = '0, ilast = '0, irdy, err;
  logic [NI-1:0][FW-1:0] iflit = '0;
  logic [NT-1:0] tv, tl, trdy = '1;
  logic [NT-1:0][FW-1:0] tf;
  logic [NT-1:0][2:0] ts;

  int n_chk = 0, n_fail = 0, cyc = 0, err_cnt = 0;
  bit done = 0;
  int hdr_cyc [NI];
  int log_n [NT] = '{0, 0, 0, 0};
  int log_src [NT][64];
  int log_cyc [NT][64];
  logic [FW-1:0] log_flit [NT][64];
  logic log_last [NT][64];

  prio_xbar_node u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_prio_i(cfg_prio),
    .ini_valid_i(iv), .ini_flit_i(iflit), .ini_last_i(ilast), .ini_ready_o(irdy), .ini_err_o(err),
    .tgt_valid_o(tv), .tgt_flit_o(tf), .tgt_last_o(tl), .tgt_src_o(ts), .tgt_ready_i(trdy)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // output monitor, away from the clock edge
  always begin
    @(negedge clk); #2;
    for (int t = 0; t < NT; t++)
      if (tv[t] && trdy[t] && log_n[t] < 64) begin
        log_src[t][log_n[t]]  = int'(ts[t]);
        log_cyc[t][log_n[t]]  = cyc;
        log_flit[t][log_n[t]] = tf[t];
        log_last[t][log_n[t]] = tl[t];
        log_n[t]++;
      end
    for (int i = 0; i < NI; i++) if (err[i]) err_cnt++;
  end

  function automatic logic [FW-1:0] hdr(int p, int t);
    logic [FW-1:0] f = '0;
    f[58:56] = 3'(t); f[15:8] = 8'(p); f[7:0] = 8'hA5;
    return f;
  endfunction

  function automatic logic [FW-1:0] pay(int p, int b);
    logic [FW-1:0] f = '0;
    f[15:8] = 8'(p); f[7:0] = 8'(b);
    return f;
  endfunction

  task automatic chk(string r, logic [FW-1:0] act, logic [FW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic send(int p, int t, int n);
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      iv[p] = 1'b1; iflit[p] = (b == 0) ? hdr(p, t) : pay(p, b); ilast[p] = (b == n-1);
      #1;
      while (!irdy[p]) begin @(negedge clk); #1; end
      if (b == 0) hdr_cyc[p] = cyc;
    end
    @(negedge clk); iv[p] = 1'b0; ilast[p] = 1'b0;
  endtask

  task automatic wr_prio(int p, int v);
    @(negedge clk); cfg_we = 1; cfg_idx = 3'(p); cfg_prio = 3'(v);
    @(negedge clk); cfg_we = 0;
  endtask

  // {a, b, prio_a, prio_b, target, expected winner}
  localparam logic [16:0] ARB_TAB [6] = '{
    {3'd0, 3'd1, 3'd0, 3'd0, 2'd0, 3'd0},
    {3'd2, 3'd5, 3'd1, 3'd4, 2'd1, 3'd5},
    {3'd3, 3'd4, 3'd7, 3'd6, 2'd2, 3'd3},
    {3'd1, 3'd4, 3'd3, 3'd3, 2'd3, 3'd1},
    {3'd5, 3'd0, 3'd2, 3'd2, 2'd0, 3'd0},
    {3'd2, 3'd3, 3'd5, 3'd0, 2'd3, 3'd2}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, all requirements actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base, b2, e0;
    repeat (3) @(negedge clk);
    #3;
    chk("R10 tgt valid", FW'(tv), '0);
    chk("R10 err", FW'(err), '0);
    rst_n = 1;
    @(negedge clk); #3;
    chk("R10 ready", FW'(irdy), '0);

    // R3 R4: table of two-way contests
    for (int k = 0; k < 6; k++) begin
      int a, b, pa, pb, t, w, l;
      {a, b, pa, pb, t, w} = {ARB_TAB[k][16:14], ARB_TAB[k][13:11], ARB_TAB[k][10:8],
                              ARB_TAB[k][7:5], ARB_TAB[k][4:3], ARB_TAB[k][2:0]};
      a = int'(ARB_TAB[k][16:14]); b = int'(ARB_TAB[k][13:11]);
      pa = int'(ARB_TAB[k][10:8]); pb = int'(ARB_TAB[k][7:5]);
      t = int'(ARB_TAB[k][4:3]);   w = int'(ARB_TAB[k][2:0]);
      l = (w == a) ? b : a;
      wr_prio(a, pa); wr_prio(b, pb);
      base = log_n[t];
      fork send(a, t, 2); send(b, t, 2); join
      repeat (3) @(negedge clk);
      chk("R3 winner first", FW'(log_src[t][base]), FW'(w));
      chk("R1 header routed", log_flit[t][base], hdr(w, t));
      chk("R4 no interleave", FW'(log_src[t][base+1]), FW'(w));
      chk("R4 last of winner", FW'(log_last[t][base+1]), 1);
      chk("R3 loser after", FW'(log_src[t][base+2]), FW'(l));
    end

    // R2 R1: grant latency and output latency
    base = log_n[2];
    @(negedge clk); iv[3] = 1; iflit[3] = hdr(3, 2); ilast[3] = 1;
    #1 chk("R2 not ready at once", FW'(irdy[3]), 0);
    @(negedge clk); #1 chk("R2 ready next cycle", FW'(irdy[3]), 1);
    @(negedge clk); iv[3] = 0; ilast[3] = 0;
    #1 chk("R1 out valid next cycle", FW'(tv[2]), 1);
    chk("R1 out src", FW'(ts[2]), 3);

    // R7: re-arbitration timing
    wr_prio(0, 0); wr_prio(1, 0);
    @(negedge clk); iv[0] = 1; iflit[0] = hdr(0, 2); ilast[0] = 1;
    iv[1] = 1; iflit[1] = hdr(1, 2); ilast[1] = 1;
    @(negedge clk); #1 chk("R7 first owner ready", FW'(irdy), FW'(6'b000001));
    @(negedge clk); iv[0] = 0; ilast[0] = 0;
    #1 chk("R7 idle cycle", FW'(irdy[1]), 0);
    @(negedge clk); #1 chk("R7 next owner ready", FW'(irdy[1]), 1);
    @(negedge clk); iv[1] = 0; ilast[1] = 0;

    // R5: concurrency
    base = log_n[0]; b2 = log_n[3];
    fork send(1, 0, 3); send(2, 3, 3); join
    repeat (2) @(negedge clk);
    chk("R5 same cycle", FW'(log_cyc[0][base]), FW'(log_cyc[3][b2]));
    chk("R5 t3 src", FW'(log_src[3][b2]), 2);
    chk("R1 acceptance+1", FW'(log_cyc[0][base]), FW'(hdr_cyc[1] + 1));

    // R6: back-pressure isolation
    @(negedge clk); trdy[0] = 0;
    base = log_n[0]; b2 = log_n[1];
    fork send(0, 0, 3); join_none
    fork send(4, 1, 2); join_none
    repeat (6) @(negedge clk); #3;
    chk("R6 held valid", FW'(tv[0]), 1);
    chk("R6 held flit", tf[0], hdr(0, 0));
    chk("R6 owner stalled", FW'(irdy[0]), 0);
    chk("R6 other target flows", FW'(log_n[1] - b2), 2);
    @(negedge clk); trdy[0] = 1;
    repeat (8) @(negedge clk);
    chk("R6 drained", FW'(log_n[0] - base), 3);
    chk("R6 last marker", FW'(log_last[0][base+2]), 1);

    // R8: bad target index
    e0 = err_cnt;
    base = log_n[0] + log_n[1] + log_n[2] + log_n[3];
    send(0, 5, 3);
    repeat (3) @(negedge clk);
    chk("R8 err pulse", FW'(err_cnt - e0), 1);
    chk("R8 nothing routed", FW'(log_n[0] + log_n[1] + log_n[2] + log_n[3]), FW'(base));
    b2 = log_n[0];
    send(0, 0, 1);
    repeat (3) @(negedge clk);
    chk("R8 discard cleared", FW'(log_n[0] - b2), 1);

    // R9: priority rewritten mid-transaction
    wr_prio(2, 0); wr_prio(3, 0); wr_prio(4, 0);
    base = log_n[1];
    fork
      send(2, 1, 6);
      begin repeat (2) @(negedge clk); fork send(3, 1, 1); send(4, 1, 1); join end
      begin repeat (3) @(negedge clk); wr_prio(4, 5); end
    join
    repeat (3) @(negedge clk);
    chk("R9 holder done first", FW'(log_src[1][base+5]), 2);
    chk("R9 new prio wins", FW'(log_src[1][base+6]), 4);
    chk("R9 lower waits", FW'(log_src[1][base+7]), 3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule